// File: doc/BRIEF.md
# Synchronous Burst Memory Responder with Stall Output

This block is the device side of a synchronous burst memory. It answers burst reads and writes to a small internal word array, and it can serve as a target model inside a larger design. A host starts an access by pulling the select low. It then strobes the start address on one clock edge, and the write-enable level on that same edge gives the direction. The responder waits out the latency the host programmed and then moves one word on each clock edge. The address goes up by one after each word.

While data is not ready, the responder raises a stall output. This covers the whole initial latency, and the stall goes high as soon as select falls. Whenever the next address starts a new 128-word row, the responder inserts a row-restore penalty. During the penalty the stall is high again and no word moves. A burst is either fixed (4, 8 or 16 words) or continuous. A continuous burst runs over the whole array and wraps at its end. Raising the select at any time ends the burst. If the clock stops, every piece of burst state stays where it is, and the burst picks up at the same word when the clock comes back.

Top module: `burst_wait_target`

## Requirements
- R1: `stall_o` is high in any cycle where `chip_sel_n` is low and the engine is in neither the data phase nor the finished state, including before any address is captured. `stall_o` is low whenever `chip_sel_n` is high.
- R2: The address (`addr_i`), direction (`write_n`, low = write), latency and length are captured at the first rising edge where the engine is idle and both `chip_sel_n` and `adr_strobe_n` are low. Strobes later in the same burst have no effect.
- R3: With `lat_cfg` = L (a value of 0 acts as 1), `stall_o` stays high for exactly L cycles after the capture edge. The first word is exchanged at the next edge.
- R4: In a read burst's data phase, with `out_en_n` low, `data_oe` is 1 and `data_o` equals the stored word at the current burst address. With `out_en_n` high, or outside a read data phase, `data_oe` is 0 and `data_o` is 0.
- R5: In a write burst, each rising edge in the data phase stores `data_i` at the current burst address. The address then advances by one.
- R6: `blen_cfg` encoding: 0 = 4 words, 1 = 8, 2 = 16, 3 = continuous. After the last word of a fixed burst, `stall_o` and `data_oe` stay 0, and further edges store nothing, until the select is raised.
- R7: The burst address goes up by one per word and wraps from the top of the array to 0. A continuous burst keeps going across the wrap.
- R8: When the next burst address has its low 7 bits all zero and the burst is not finishing, `stall_o` is high for a row penalty of `ROW_STALL` cycles before the next word. `ROW_STALL` = 0 means the captured latency L is used. The burst then continues at that next address.
- R9: `chip_sel_n` high at a rising edge returns the engine to idle. Lowering the select again without a strobe starts no burst: `stall_o` stays high and no data is driven.
- R10: If the clock is held mid-burst, outputs and burst position are held. On restart the burst continues with the same word.
- R11: Asynchronous active-low reset puts the engine in idle. After reset, with the select high, `stall_o` and `data_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low select; high ends any burst |
| adr_strobe_n | input | 1 | Active-low address strobe |
| write_n | input | 1 | Direction at capture: 0 write, 1 read |
| out_en_n | input | 1 | Active-low read output enable |
| addr_i | input | AW (10) | Burst start word address |
| lat_cfg | input | LAT_W (4) | Initial latency in cycles (0 acts as 1) |
| blen_cfg | input | 2 | Burst length code |
| data_i | input | DW (16) | Write data |
| data_o | output | DW (16) | Read data, 0 when not driven |
| data_oe | output | 1 | Read data driver enable |
| stall_o | output | 1 | High while data is not ready |

## Verification
The assertions check on every cycle that a raised select forces idle and that a strobe while idle always leads to the latency state. They also check that a finished fixed burst stays finished, that a row crossing during the data phase enters the penalty state, that every word moves the address by exactly one with wrap, and that read data is only driven with the output enable low and the stall low. The exact latency and penalty lengths, the stored and returned data values, the ignoring of late strobes and of writes after a burst ends, and the hold of state while the clock is stopped can only be shown by the bench's scenarios.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  // Engine phases of one burst
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for an address strobe
    ST_LAT  = 3'd1,  // counting initial latency
    ST_DATA = 3'd2,  // one word per edge
    ST_ROW  = 3'd3,  // row-restore penalty
    ST_DONE = 3'd4   // fixed burst finished
  } eng_state_e;

  // Burst length codes
  typedef enum logic [1:0] {
    BL_4    = 2'd0,
    BL_8    = 2'd1,
    BL_16   = 2'd2,
    BL_CONT = 2'd3
  } blen_e;

endpackage

// File: rtl/bwt_seq.sv
module bwt_seq
  import bwt_pkg::*;
#(
  parameter int LAT_W     = 4,
  parameter int ROW_STALL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             strobe_n,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic             beat_last,
  input  logic             row_cross,
  output logic             capture,
  output logic             advance,
  output logic             stall_o,
  output eng_state_e       state_o
);

  localparam int STALL_W = $clog2(ROW_STALL + 2);
  localparam int TMR_W   = (STALL_W > LAT_W) ? STALL_W : LAT_W;

  eng_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d, stall_len;
  logic             tmr_en;
  logic [LAT_W-1:0] lat_q, lat_eff;

  assign lat_eff = (lat_cfg == '0) ? LAT_W'(1) : lat_cfg;

  // Row penalty either follows the captured latency or is fixed
  generate
    if (ROW_STALL == 0) begin : g_pen_lat
      assign stall_len = TMR_W'(lat_q);
    end else begin : g_pen_fix
      assign stall_len = TMR_W'(ROW_STALL);
    end
  endgenerate

  assign capture = !sel_n && !strobe_n && (state_q == ST_IDLE);
  assign advance = !sel_n && (state_q == ST_DATA);
  assign stall_o = !sel_n && (state_q != ST_DATA) && (state_q != ST_DONE);
  assign state_o = state_q;

  // Next-state process
  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    tmr_en  = 1'b0;
    if (sel_n) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!strobe_n) begin
            state_d = ST_LAT;
            tmr_d   = TMR_W'(lat_eff) - TMR_W'(1);
            tmr_en  = 1'b1;
          end
        end
        ST_LAT, ST_ROW: begin
          if (tmr_q == '0) begin
            state_d = ST_DATA;
          end else begin
            tmr_d  = tmr_q - TMR_W'(1);
            tmr_en = 1'b1;
          end
        end
        ST_DATA: begin
          if (beat_last) begin
            state_d = ST_DONE;
          end else if (row_cross) begin
            state_d = ST_ROW;
            tmr_d   = stall_len - TMR_W'(1);
            tmr_en  = 1'b1;
          end
        end
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (tmr_en)  tmr_q <= tmr_d;
      if (capture) lat_q <= lat_eff;
    end
  end

  // R9: a raised select always lands in idle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (state_q == ST_IDLE));

  // R2: a strobe while idle always starts the latency count
  p_capture_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (state_q == ST_LAT));

  // R6: a finished fixed burst stays finished while selected
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DONE) && !sel_n) |=> (state_q == ST_DONE));

  // R8: a row crossing that is not the last word enters the penalty
  p_row_penalty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && row_cross && !beat_last) |=> (state_q == ST_ROW));

endmodule

// File: rtl/bwt_addr.sv
module bwt_addr
  import bwt_pkg::*;
#(
  parameter int AW       = 10,
  parameter int ROW_BITS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          advance,
  input  logic [AW-1:0] addr_i,
  input  logic          write_n,
  input  logic [1:0]    blen_cfg,
  output logic [AW-1:0] cur_addr,
  output logic          is_write,
  output logic          beat_last,
  output logic          row_cross
);

  localparam int BEAT_W = 4;

  logic [AW-1:0]     addr_q, addr_d, addr_nxt;
  logic [BEAT_W-1:0] beat_q, beat_d, last_idx;
  blen_e             blen_q;
  logic              wr_q;
  logic              step_en;

  assign addr_nxt  = addr_q + AW'(1);
  assign row_cross = (addr_nxt[ROW_BITS-1:0] == '0);
  assign step_en   = capture || advance;

  always_comb begin
    unique case (blen_q)
      BL_4:    last_idx = BEAT_W'(3);
      BL_8:    last_idx = BEAT_W'(7);
      BL_16:   last_idx = BEAT_W'(15);
      default: last_idx = '0;
    endcase
  end

  assign beat_last = (blen_q != BL_CONT) && (beat_q == last_idx);

  // Next-state process
  always_comb begin
    if (capture) begin
      addr_d = addr_i;
      beat_d = '0;
    end else begin
      addr_d = addr_nxt;
      beat_d = beat_q + BEAT_W'(1);
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      beat_q <= '0;
      blen_q <= BL_4;
      wr_q   <= 1'b0;
    end else begin
      if (step_en) begin
        addr_q <= addr_d;
        beat_q <= beat_d;
      end
      if (capture) begin
        blen_q <= blen_e'(blen_cfg);
        wr_q   <= !write_n;
      end
    end
  end

  assign cur_addr = addr_q;
  assign is_write = wr_q;

  // R7: each word moves the address by exactly one, wrapping at the top
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (addr_q == AW'($past(addr_q) + AW'(1))));

endmodule

// File: rtl/bwt_store.sv
module bwt_store #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/burst_wait_target.sv
module burst_wait_target
  import bwt_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter int LAT_W     = 4,
  parameter int ROW_BITS  = 7,
  parameter int ROW_STALL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_sel_n,
  input  logic             adr_strobe_n,
  input  logic             write_n,
  input  logic             out_en_n,
  input  logic [AW-1:0]    addr_i,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic [1:0]       blen_cfg,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe,
  output logic             stall_o
);

  logic          capture, advance, beat_last, row_cross, is_write;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rdata;
  eng_state_e    state;

  bwt_seq #(
    .LAT_W    (LAT_W),
    .ROW_STALL(ROW_STALL)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (chip_sel_n),
    .strobe_n (adr_strobe_n),
    .lat_cfg  (lat_cfg),
    .beat_last(beat_last),
    .row_cross(row_cross),
    .capture  (capture),
    .advance  (advance),
    .stall_o  (stall_o),
    .state_o  (state)
  );

  bwt_addr #(
    .AW      (AW),
    .ROW_BITS(ROW_BITS)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .advance  (advance),
    .addr_i   (addr_i),
    .write_n  (write_n),
    .blen_cfg (blen_cfg),
    .cur_addr (cur_addr),
    .is_write (is_write),
    .beat_last(beat_last),
    .row_cross(row_cross)
  );

  bwt_store #(
    .AW(AW),
    .DW(DW)
  ) u_store (
    .clk  (clk),
    .wr_en(advance && is_write),
    .addr (cur_addr),
    .wdata(data_i),
    .rdata(rdata)
  );

  assign data_oe = advance && !is_write && !out_en_n;
  assign data_o  = data_oe ? rdata : '0;

  // R4: read data only leaves with output enable low and no stall
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!out_en_n && !stall_o && (state == ST_DATA)));

endmodule

// File: tb/test_burst_wait_target.sv
module test_burst_wait_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chip_sel_n, adr_strobe_n, write_n, out_en_n;
  logic [AW-1:0] addr_i;
  logic [3:0]    lat_cfg;
  logic [1:0]    blen_cfg;
  logic [DW-1:0] data_i, data_o;
  logic          data_oe, stall_o;
  bit            clk_run = 1'b1;

  logic [DW-1:0] model [DEPTH];
  int vectors = 0;
  int miscompares = 0;

  burst_wait_target i_burst_wait_target (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n),
    .adr_strobe_n(adr_strobe_n), .write_n(write_n), .out_en_n(out_en_n),
    .addr_i(addr_i), .lat_cfg(lat_cfg), .blen_cfg(blen_cfg),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .stall_o(stall_o)
  );

  always #(CLK_PERIOD/2) if (clk_run) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'(a * 37 + seed * 4099 + 16'h1111);
  endfunction

  // One burst: capture, latency, beats (with row penalties), tail
  task automatic do_burst(input int start, input bit wr, input int lat,
                          input int bl, input int beats, input bit oe_low,
                          input int pause_beat, input bit glitch, input int seed);
    int leff, len, n;
    logic [DW-1:0] held;
    leff = (lat == 0) ? 1 : lat;
    len  = (bl == 3) ? 0 : (4 << bl);
    step();
    chip_sel_n = 1'b0; adr_strobe_n = 1'b0; addr_i = AW'(start);
    write_n = !wr; lat_cfg = 4'(lat); blen_cfg = 2'(bl); out_en_n = !oe_low;
    step();
    adr_strobe_n = 1'b1; write_n = 1'b1; addr_i = '0;
    n = 0;
    while (stall_o && n < 64) begin
      n++;
      if (glitch && n == 1) begin
        adr_strobe_n = 1'b0; addr_i = AW'(300); write_n = 1'b0;
      end else begin
        adr_strobe_n = 1'b1; write_n = 1'b1;
      end
      step();
    end
    adr_strobe_n = 1'b1; write_n = 1'b1;
    check("R3", "latency cycles", n, leff);
    for (int b = 0; b < beats; b++) begin
      int a;
      a = (start + b) % DEPTH;
      if (b > 0 && (a % 128) == 0) begin
        n = 0;
        while (stall_o && n < 64) begin n++; step(); end
        check("R8", "row penalty cycles", n, leff);
      end
      check("R1", "stall low in data phase", stall_o, 0);
      if (wr) begin
        data_i = pat(a, seed);
        model[a] = data_i;
        check("R4", "no drive during write", data_oe, 0);
      end else if (oe_low) begin
        check("R4", "read enable", data_oe, 1);
        check(a >= 1016 || a < 8 ? "R7" : "R4", "read data", data_o, model[a]);
      end else begin
        check("R4", "released with out_en_n high", {data_oe, data_o}, 0);
      end
      if (b == pause_beat) begin
        held = data_o;
        clk_run = 1'b0;
        #(CLK_PERIOD*4 + 3);
        check("R10", "data held while clock stopped", data_o, held);
        check("R10", "stall held low while clock stopped", stall_o, 0);
        #(CLK_PERIOD*3);
        check("R10", "enable held while clock stopped", data_oe, 1);
        clk_run = 1'b1;
      end
      step();
    end
    if (len != 0 && beats == len) begin
      for (int k = 0; k < 3; k++) begin
        data_i = 16'hDEAD;
        check("R6", "stall after last word", stall_o, 0);
        check("R6", "no drive after last word", data_oe, 0);
        step();
      end
    end
    chip_sel_n = 1'b1;
    step();
  endtask

  task automatic t_reset_state();
    check("R11", "stall after reset", stall_o, 0);
    check("R11", "data_oe after reset", data_oe, 0);
    chip_sel_n = 1'b0;
    #1;
    check("R1", "stall on select before strobe", stall_o, 1);
    step(); step();
    check("R1", "stall held without strobe", stall_o, 1);
    chip_sel_n = 1'b1;
    #1;
    check("R1", "stall low when deselected", stall_o, 0);
    step();
  endtask

  task automatic t_write_read_rows();
    do_burst(120, 1, 3, 2, 16, 0, -1, 0, 1);   // R5 R8 write across a row
    do_burst(120, 0, 3, 2, 16, 1, -1, 0, 0);   // R4 R8 read back
    do_burst(120, 0, 0, 0, 4, 1, -1, 0, 0);    // R3 latency 0 acts as 1, R6 length 4
  endtask

  task automatic t_continuous_wrap();
    do_burst(1016, 1, 1, 3, 16, 0, -1, 0, 2);  // R7 writes wrap to 0
    do_burst(1016, 0, 2, 3, 16, 1, -1, 0, 0);  // R7 reads across the wrap
  endtask

  task automatic t_fixed_end_ignored();
    do_burst(300, 1, 2, 1, 8, 0, -1, 0, 3);    // fill 300..307
    do_burst(300, 1, 2, 0, 4, 0, -1, 0, 4);    // R6 tail writes must not land
    do_burst(300, 0, 2, 1, 8, 1, -1, 0, 0);    // R6 304..307 keep old data
  endtask

  task automatic t_oe_release();
    do_burst(120, 0, 2, 0, 4, 0, -1, 0, 0);    // R4 released
  endtask

  task automatic t_strobe_ignored();
    do_burst(120, 0, 3, 1, 8, 1, -1, 1, 0);    // R2 late strobe to 300 ignored
  endtask

  task automatic t_abort();
    step();
    chip_sel_n = 1'b0; adr_strobe_n = 1'b0; addr_i = AW'(120);
    write_n = 1'b1; lat_cfg = 4'd2; blen_cfg = 2'd2; out_en_n = 1'b0;
    step();
    adr_strobe_n = 1'b1;
    step(); step(); step();
    check("R9", "in data phase before abort", data_oe, 1);
    chip_sel_n = 1'b1;
    #1;
    check("R9", "stall low on abort", stall_o, 0);
    check("R9", "drive off on abort", data_oe, 0);
    step();
    chip_sel_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R9", "no burst without strobe: stall", stall_o, 1);
      check("R9", "no burst without strobe: drive", data_oe, 0);
    end
    chip_sel_n = 1'b1;
    step();
    do_burst(128, 0, 1, 0, 4, 1, -1, 0, 0);    // R9 fresh burst works
  endtask

  task automatic t_clock_pause();
    do_burst(122, 0, 2, 1, 8, 1, 3, 0, 0);     // R10 pause at word 3
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; chip_sel_n = 1'b1; adr_strobe_n = 1'b1; write_n = 1'b1;
    out_en_n = 1'b1; addr_i = '0; lat_cfg = 4'd1; blen_cfg = 2'd0; data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_write_read_rows();
    t_continuous_wrap();
    t_fixed_end_ignored();
    t_oe_release();
    t_strobe_ignored();
    t_abort();
    t_clock_pause();
    summary();
  end
endmodule